// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores incoming packets in a 16-entry receive ring that lives in an external byte-wide memory. Each ring entry has an 8-byte descriptor and a fixed 1544-byte buffer. When a packet begins, the engine looks at descriptors starting at its own receive pointer and takes the first one the host has handed to the controller. It writes the payload into that entry's buffer, then writes the received length, and finally rewrites the status byte so the host owns the entry again.

The packet arrives as a byte stream that carries start and end markers and a ready signal. The engine holds the stream back while it searches the ring. If no entry is free, it consumes the packet and discards it. A stop input halts all activity. A "can receive" output tells the packet source whether at least one entry is currently free. To produce it, the engine reads descriptor status bytes in the background whenever it is idle.

Top module: `rx_ring_engine`

## Requirements
- R1: The ring has 16 entries. Descriptor i starts at byte address DESC_BASE+8*i and buffer i at BUF_BASE+1544*i. All entry indices wrap modulo 16, so entry 0 follows entry 15.
- R2: While stop_i is high, pkt_ready is low and no memory access is issued.
- R3: An entry is usable only when its status byte (descriptor offset 2) equals exactly 0x80. Any other value, including 0x80 with extra bits set, is passed over.
- R4: The search starts at the receive pointer and looks at no more than 15 entries, so the entry just behind the start is never taken. If the search finds nothing, the packet is consumed and discarded: nothing is written, no rx_done is given, and the pointer does not move.
- R5: After a packet is stored in entry k, the receive pointer becomes k+1 modulo 16.
- R6: The stored byte count plus 4 is written to the length field, with the high byte at descriptor offset 6 and the low byte at offset 7.
- R7: The status byte is written with 0x03 after the payload and the length. rx_done pulses for exactly one cycle, one cycle after that write.
- R8: Bytes past the 1544th are discarded and never written. The length field then reads 1548.
- R9: can_rx is high when stop_i is low and at least one entry's status byte, as most recently read, equals 0x80. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_i | input | 1 | Halt: no input accepted, no memory traffic |
| pkt_valid | input | 1 | Stream byte valid |
| pkt_sop | input | 1 | First byte of a packet |
| pkt_eop | input | 1 | Last byte of a packet |
| pkt_data | input | 8 | Stream byte |
| pkt_ready | output | 1 | Byte taken at this clock edge |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |
| can_rx | output | 1 | A free ring entry is known |
| rx_done | output | 1 | One-cycle pulse for each stored packet |

## Verification
Packets are sent into a ring where every entry is free, to confirm that successive entries are used in order. A ring with entries marked 0x81 and 0x00 ahead of a free entry shows that the exact-equality ownership test is applied. A ring whose only free entry sits just behind the pointer tells the 15-entry search window apart from a full wrap and exercises the discard path. A ring with only entries 15 and 0 free exercises pointer wraparound. An oversized packet, checked against a sentinel byte in the next buffer, tells truncation apart from overrun.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int ADDR_W    = 24,
  parameter int DESC_BASE = 0,
  parameter int BUF_BASE  = 128,
  parameter int BUF_BYTES = 1544,
  parameter int RING_LOG  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_i,
  input  logic              pkt_valid,
  input  logic              pkt_sop,
  input  logic              pkt_eop,
  input  logic [7:0]        pkt_data,
  output logic              pkt_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              can_rx,
  output logic              rx_done
);
  localparam int RING  = 1 << RING_LOG;
  localparam int OFF_W = $clog2(BUF_BYTES + 1);
  localparam logic [OFF_W-1:0]    OFF_MAX  = OFF_W'(BUF_BYTES);
  localparam logic [RING_LOG-1:0] LAST_CNT = RING_LOG'(RING - 2);
  localparam logic [7:0] ST_FREE = 8'h80;
  localparam logic [7:0] ST_DONE = 8'h03;

  typedef enum logic [2:0] {IDLE, SCAN, SWAIT, COPY, DROP, LENH, LENL, STAT} st_t;

  st_t                 st;
  logic [RING_LOG-1:0] ptr, idx, cnt, poll_idx, poll_q;
  logic [OFF_W-1:0]    off;
  logic [RING-1:0]     owned;
  logic                poll_v, done_q;
  logic [15:0]         len;
  logic [ADDR_W-1:0]   desc_a, buf_a, poll_a;

  assign len    = 16'(off) + 16'd4;
  assign desc_a = ADDR_W'(DESC_BASE) + (ADDR_W'(idx) << 3);
  assign poll_a = ADDR_W'(DESC_BASE) + (ADDR_W'(poll_idx) << 3) + ADDR_W'(2);
  assign buf_a  = ADDR_W'(BUF_BASE) + ADDR_W'(idx) * ADDR_W'(BUF_BYTES) + ADDR_W'(off);

  assign pkt_ready = !stop_i && (st == COPY || st == DROP || (st == IDLE && !pkt_sop));
  assign can_rx    = !stop_i && (|owned);
  assign rx_done   = done_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (!stop_i) begin
      case (st)
        IDLE: begin mem_req = 1'b1; mem_addr = poll_a; end
        SCAN: begin mem_req = 1'b1; mem_addr = desc_a + ADDR_W'(2); end
        COPY: begin
          mem_req   = pkt_valid && (off < OFF_MAX);
          mem_we    = 1'b1;
          mem_addr  = buf_a;
          mem_wdata = pkt_data;
        end
        LENH: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_a + ADDR_W'(6); mem_wdata = len[15:8]; end
        LENL: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_a + ADDR_W'(7); mem_wdata = len[7:0]; end
        STAT: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = desc_a + ADDR_W'(2); mem_wdata = ST_DONE; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      ptr      <= '0;
      idx      <= '0;
      cnt      <= '0;
      off      <= '0;
      owned    <= '0;
      poll_idx <= '0;
      poll_q   <= '0;
      poll_v   <= 1'b0;
      done_q   <= 1'b0;
    end else if (stop_i) begin
      st     <= IDLE;
      poll_v <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st == STAT);
      poll_v <= (st == IDLE);
      poll_q <= poll_idx;
      if (st == IDLE) poll_idx <= poll_idx + 1'b1;
      if (poll_v) owned[poll_q] <= (mem_rdata == ST_FREE);
      case (st)
        IDLE: if (pkt_valid && pkt_sop) begin
          st  <= SCAN;
          idx <= ptr;
          cnt <= '0;
        end
        SCAN: st <= SWAIT;
        SWAIT: begin
          owned[idx] <= (mem_rdata == ST_FREE);
          if (mem_rdata == ST_FREE) begin
            st  <= COPY;
            off <= '0;
          end else if (cnt == LAST_CNT) begin
            st <= DROP;
          end else begin
            idx <= idx + 1'b1;
            cnt <= cnt + 1'b1;
            st  <= SCAN;
          end
        end
        COPY: if (pkt_valid) begin
          if (off < OFF_MAX) off <= off + 1'b1;
          if (pkt_eop) st <= LENH;
        end
        DROP: if (pkt_valid && pkt_eop) st <= IDLE;
        LENH: st <= LENL;
        LENL: st <= STAT;
        STAT: begin
          owned[idx] <= 1'b0;
          ptr        <= idx + 1'b1;
          st         <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk #(
  parameter int ADDR_W    = 24,
  parameter int BUF_BASE  = 128,
  parameter int BUF_BYTES = 1544,
  parameter int RING_LOG  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_i,
  input logic              pkt_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              can_rx,
  input logic              rx_done
);
  localparam longint BUF_END = longint'(BUF_BASE) + longint'(BUF_BYTES) * (longint'(1) << RING_LOG);

  assert_no_mem_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !mem_req);
  assert_no_accept_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !pkt_ready);
  assert_write_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && longint'(mem_addr) >= longint'(BUF_BASE)) |-> longint'(mem_addr) < BUF_END);
  assert_done_after_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(mem_req && mem_we && mem_wdata == 8'h03));
  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  assert_no_can_rx_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !can_rx);
endmodule

bind rx_ring_engine rx_ring_engine_chk #(
  .ADDR_W(ADDR_W), .BUF_BASE(BUF_BASE), .BUF_BYTES(BUF_BYTES), .RING_LOG(RING_LOG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .pkt_ready(pkt_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .can_rx(can_rx), .rx_done(rx_done)
);

// File: tb/rx_ring_engine_bench.sv
`timescale 1ns/1ps
module rx_ring_engine_bench;
  localparam int AW = 24, DB = 0, BB = 128, BUFSZ = 1544;

  logic clk = 1'b0, rst_n = 1'b0, stop_i = 1'b0;
  logic pkt_valid = 1'b0, pkt_sop = 1'b0, pkt_eop = 1'b0;
  logic [7:0] pkt_data = '0;
  logic pkt_ready, mem_req, mem_we, can_rx, rx_done;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  rx_ring_engine #(.ADDR_W(AW), .DESC_BASE(DB), .BUF_BASE(BB), .BUF_BYTES(BUFSZ)) u_rx_ring_engine (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .pkt_valid(pkt_valid), .pkt_sop(pkt_sop),
    .pkt_eop(pkt_eop), .pkt_data(pkt_data), .pkt_ready(pkt_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .can_rx(can_rx), .rx_done(rx_done));

  logic [7:0] mem [int];
  int wr_count = 0, checks = 0, errors = 0, done_count = 0;
  bit finished = 0;

  typedef struct { int slot; int len; int seed; } item_t;
  item_t exp_q[$];

  function automatic logic [7:0] rd(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) if (mem_req) begin
    if (mem_we) begin mem[int'(mem_addr)] = mem_wdata; wr_count++; end
    else mem_rdata <= rd(int'(mem_addr));
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0d expected %0d", req, act, exp); end
  endtask

  function automatic int st_a(int i); return DB + 8*i + 2; endfunction

  task automatic set_all(logic [7:0] v);
    for (int i = 0; i < 16; i++) mem[st_a(i)] = v;
  endtask

  always @(negedge clk) if (rst_n && rx_done) begin
    item_t it;
    int n, bad, base;
    done_count++;
    if (exp_q.size() == 0) chk(0, "R4 unexpected rx_done", 1, 0);
    else begin
      it   = exp_q.pop_front();
      n    = (it.len > BUFSZ) ? BUFSZ : it.len;
      base = BB + it.slot * BUFSZ;
      chk(rd(st_a(it.slot)) == 8'h03, "R7/R3 status of expected slot", rd(st_a(it.slot)), 3);
      chk({rd(DB+8*it.slot+6), rd(DB+8*it.slot+7)} == 16'(n + 4), "R6 length field",
          {rd(DB+8*it.slot+6), rd(DB+8*it.slot+7)}, n + 4);
      bad = 0;
      for (int i = 0; i < n; i++) if (rd(base + i) != 8'(it.seed + i)) bad++;
      chk(bad == 0, "R1 payload bytes mismatching", bad, 0);
    end
  end

  task automatic send_pkt(int len, int seed, int slot);
    if (slot >= 0) exp_q.push_back('{slot, len, seed});
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pkt_valid = 1'b1; pkt_sop = (i == 0); pkt_eop = (i == len - 1); pkt_data = 8'(seed + i);
      #0.5;
      while (!pkt_ready) begin @(negedge clk); #0.5; end
      @(posedge clk);
    end
    @(negedge clk);
    pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    int w0, d0, rdy;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_done == 0, "R7 reset rx_done", rx_done, 0);
    repeat (20) @(negedge clk);
    chk(can_rx == 0, "R9 reset can_rx with empty ring", can_rx, 0);

    set_all(8'h80);
    repeat (40) @(negedge clk);
    chk(can_rx == 1, "R9 can_rx with free entries", can_rx, 1);

    stop_i = 1'b1; pkt_valid = 1'b1; pkt_sop = 1'b1;
    w0 = wr_count; rdy = 0;
    repeat (20) begin @(negedge clk); #0.5; if (pkt_ready) rdy++; end
    chk(rdy == 0, "R2 ready while stopped", rdy, 0);
    chk(wr_count == w0, "R2 writes while stopped", wr_count - w0, 0);
    chk(can_rx == 0, "R9 can_rx while stopped", can_rx, 0);
    pkt_valid = 1'b0; pkt_sop = 1'b0; stop_i = 1'b0;
    repeat (4) @(negedge clk);

    send_pkt(60, 1, 0);
    send_pkt(17, 9, 1);

    mem[st_a(2)] = 8'h81; mem[st_a(3)] = 8'h00;
    send_pkt(33, 50, 4);

    set_all(8'h00); mem[st_a(4)] = 8'h80;
    w0 = wr_count; d0 = done_count;
    send_pkt(20, 70, -1);
    chk(done_count == d0, "R4 no rx_done on drop", done_count - d0, 0);
    chk(wr_count == w0, "R4 no writes on drop", wr_count - w0, 0);
    chk(rd(st_a(4)) == 8'h80, "R4 entry behind pointer untouched", rd(st_a(4)), 128);

    mem[st_a(5)] = 8'h80;
    send_pkt(25, 90, 5);

    set_all(8'h00); mem[st_a(15)] = 8'h80; mem[st_a(0)] = 8'h80;
    send_pkt(40, 3, 15);
    send_pkt(41, 4, 0);

    mem[st_a(1)] = 8'h80;
    mem[BB + 2*BUFSZ] = 8'h5A;
    send_pkt(1550, 7, 1);
    chk(rd(BB + 2*BUFSZ) == 8'h5A, "R8 no write past buffer", rd(BB + 2*BUFSZ), 90);

    repeat (40) @(negedge clk);
    chk(can_rx == 0, "R9 can_rx with no free entry", can_rx, 0);
    chk(exp_q.size() == 0, "R7 every stored packet signalled", exp_q.size(), 0);
    chk(done_count == 7, "R5 stored packet count", done_count, 7);
    finish_run();
  end
endmodule